// File: doc/BRIEF.md
# Periodic Real-Time Interrupt Generator

This block raises a sticky periodic flag at a fixed multiple of the bus clock and, when software has enabled it, turns that flag into an interrupt request. The interval is a base count of `2^BASE_LOG2` bus cycles, which is 8192 at the default setting. A small rate-select field scales this base by one, two, four or eight. Software clears the flag by writing a one to it. Writing a zero to the clear port leaves the flag as it is.

Timing always runs from the previous expiry, not from the moment software clears the flag. A handler that is slow to acknowledge therefore does not shift later ticks. Rewriting the rate field restarts the interval from zero under the new rate and never raises the flag itself. This gives software a clean way to re-phase the tick. All registers and outputs are clocked and use a synchronous active-high reset.

Top module: `rti_periodic_irq`

## Requirements
- R1: While `rst` is high at a clock edge, the flag, the enable, the interrupt request and the rate field are all cleared after that edge.
- R2: With rate field value n (0 to 3), the flag is set exactly `2^(BASE_LOG2+n)` clock edges after the last edge that restarted timing, where a restart is either reset or a rate write.
- R3: After each expiry, the next expiry follows exactly one period later, whenever the flag was cleared in between.
- R4: A rate write restarts the interval from zero and never sets the flag. This holds even when the write lands on the edge where the old interval would have expired.
- R5: A write on the clear port with data bit 1 clears the flag. The same write with data bit 0 leaves the flag unchanged.
- R6: If an expiry and a clear-with-one fall on the same edge, the flag is set after that edge.
- R7: `irq` is high exactly when both the flag and the enable are high, in the same cycle as those registers.
- R8: An enable write loads `en_wdata` into the enable at that edge.
- R9: A rate write loads `rate_wdata` into the rate field at that edge, and the new value is read back on `rate_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_wr | input | 1 | Write strobe for the rate field |
| rate_wdata | input | RATE_W (2) | New rate value n |
| en_wr | input | 1 | Write strobe for the interrupt enable |
| en_wdata | input | 1 | New enable value |
| flag_w1c_wr | input | 1 | Write strobe for the flag clear port |
| flag_w1c_bit | input | 1 | Clear data: 1 clears the flag, 0 has no effect |
| rate_q | output | RATE_W (2) | Current rate field |
| en_q | output | 1 | Current interrupt enable |
| flag_q | output | 1 | Periodic flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- the reset state;
- that the flag holds unless a clear-with-one arrives;
- that a rate write never makes the flag rise;
- the gating of `irq`;
- the loading of the rate and enable fields.

The exact interval lengths can only be shown by the bench's scenarios. The same applies to the absence of drift when the clear is placed at each offset inside a period, to restarts at early, middle and terminal offsets, and to a clear colliding with an expiry. The bench runs a small base count and sweeps these cases over all four rates.

// File: rtl/rti_pkg.sv
package rti_pkg;
  localparam int RATE_W_DEF    = 2;
  localparam int BASE_LOG2_DEF = 13;

  // Width of a counter that spans the longest period for a given config.
  function automatic int cnt_width(input int base_log2, input int rate_w);
    return base_log2 + (1 << rate_w) - 1;
  endfunction
endpackage

// File: rtl/rti_rate_reg.sv
module rti_rate_reg #(
  parameter int RATE_W = rti_pkg::RATE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [RATE_W-1:0] wdata,
  output logic [RATE_W-1:0] rate_q,
  output logic              restart
);
  always_ff @(posedge clk) begin
    if (rst)     rate_q <= '0;
    else if (wr) rate_q <= wdata;
  end

  // Any write to the field re-phases the interval.
  assign restart = wr;
endmodule

// File: rtl/rti_period_counter.sv
module rti_period_counter #(
  parameter int BASE_LOG2 = rti_pkg::BASE_LOG2_DEF,
  parameter int RATE_W    = rti_pkg::RATE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [RATE_W-1:0] rate,
  output logic              expire
);
  localparam int CNT_W   = rti_pkg::cnt_width(BASE_LOG2, RATE_W);
  localparam int N_RATES = 1 << RATE_W;

  logic [CNT_W-1:0] term_tbl [N_RATES];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;
  logic             at_term;

  // Terminal count per rate: 2^(BASE_LOG2+r) - 1 (wraps to all ones at top).
  for (genvar r = 0; r < N_RATES; r++) begin : g_term
    assign term_tbl[r] = (CNT_W'(1) << (BASE_LOG2 + r)) - CNT_W'(1);
  end

  assign term    = term_tbl[rate];
  assign at_term = (cnt_q == term);
  // A restart on the terminal edge suppresses the expiry.
  assign expire  = at_term && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (at_term)   cnt_q <= '0;
    else                cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/rti_flag_irq.sv
module rti_flag_irq (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr_wr,
  input  logic clr_bit,
  input  logic en_wr,
  input  logic en_wdata,
  output logic flag_q,
  output logic en_q,
  output logic irq_q
);
  logic flag_d;
  logic en_d;

  // Set has priority so that an expiry is never lost to a racing clear.
  assign flag_d = set || (flag_q && !(clr_wr && clr_bit));
  assign en_d   = en_wr ? en_wdata : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
      irq_q  <= flag_d && en_d;
    end
  end
endmodule

// File: rtl/rti_periodic_irq.sv
module rti_periodic_irq #(
  parameter int BASE_LOG2 = rti_pkg::BASE_LOG2_DEF,
  parameter int RATE_W    = rti_pkg::RATE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rate_wr,
  input  logic [RATE_W-1:0] rate_wdata,
  input  logic              en_wr,
  input  logic              en_wdata,
  input  logic              flag_w1c_wr,
  input  logic              flag_w1c_bit,
  output logic [RATE_W-1:0] rate_q,
  output logic              en_q,
  output logic              flag_q,
  output logic              irq
);
  logic restart;
  logic expire;

  rti_rate_reg #(.RATE_W(RATE_W)) u_rate (
    .clk(clk), .rst(rst), .wr(rate_wr), .wdata(rate_wdata),
    .rate_q(rate_q), .restart(restart)
  );

  rti_period_counter #(.BASE_LOG2(BASE_LOG2), .RATE_W(RATE_W)) u_cnt (
    .clk(clk), .rst(rst), .restart(restart), .rate(rate_q), .expire(expire)
  );

  rti_flag_irq u_flag (
    .clk(clk), .rst(rst), .set(expire),
    .clr_wr(flag_w1c_wr), .clr_bit(flag_w1c_bit),
    .en_wr(en_wr), .en_wdata(en_wdata),
    .flag_q(flag_q), .en_q(en_q), .irq_q(irq)
  );
endmodule

// File: rtl/rti_periodic_irq_chk.sv
module rti_periodic_irq_chk #(
  parameter int RATE_W = rti_pkg::RATE_W_DEF
) (
  input logic              clk,
  input logic              rst,
  input logic              rate_wr,
  input logic [RATE_W-1:0] rate_wdata,
  input logic              en_wr,
  input logic              en_wdata,
  input logic              flag_w1c_wr,
  input logic              flag_w1c_bit,
  input logic [RATE_W-1:0] rate_q,
  input logic              en_q,
  input logic              flag_q,
  input logic              irq
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!flag_q && !en_q && !irq && rate_q == '0));

  a_r4_write_no_set: assert property (@(posedge clk) disable iff (rst)
    (rate_wr && !flag_q) |=> !flag_q);

  a_r4_rise_not_from_write: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> !$past(rate_wr));

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(flag_w1c_wr && flag_w1c_bit)) |=> flag_q);

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq == (flag_q && en_q));

  a_r8_en_load: assert property (@(posedge clk) disable iff (rst)
    en_wr |=> (en_q == $past(en_wdata)));

  a_r9_rate_load: assert property (@(posedge clk) disable iff (rst)
    rate_wr |=> (rate_q == $past(rate_wdata)));
endmodule

bind rti_periodic_irq rti_periodic_irq_chk #(.RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst(rst), .rate_wr(rate_wr), .rate_wdata(rate_wdata),
  .en_wr(en_wr), .en_wdata(en_wdata),
  .flag_w1c_wr(flag_w1c_wr), .flag_w1c_bit(flag_w1c_bit),
  .rate_q(rate_q), .en_q(en_q), .flag_q(flag_q), .irq(irq)
);

// File: tb/tb_rti_periodic_irq.sv
module tb_rti_periodic_irq;
  localparam int BASE_LOG2 = 3;
  localparam int RATE_W    = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rate_wr = 1'b0;
  logic [RATE_W-1:0] rate_wdata = '0;
  logic en_wr = 1'b0, en_wdata = 1'b0;
  logic flag_w1c_wr = 1'b0, flag_w1c_bit = 1'b0;
  logic [RATE_W-1:0] rate_q;
  logic en_q, flag_q, irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;  // 50 MHz

  rti_periodic_irq #(.BASE_LOG2(BASE_LOG2), .RATE_W(RATE_W)) dut (
    .clk(clk), .rst(rst), .rate_wr(rate_wr), .rate_wdata(rate_wdata),
    .en_wr(en_wr), .en_wdata(en_wdata),
    .flag_w1c_wr(flag_w1c_wr), .flag_w1c_bit(flag_w1c_bit),
    .rate_q(rate_q), .en_q(en_q), .flag_q(flag_q), .irq(irq)
  );

  function automatic int period(input int r);
    return 1 << (BASE_LOG2 + r);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Count edges until the flag is seen high (flag must start low).
  task automatic wait_flag(output int n);
    n = 0;
    while (!flag_q && n < 300) begin
      step();
      n++;
    end
  endtask

  task automatic write_rate(input int r);
    rate_wr = 1'b1; rate_wdata = RATE_W'(r);
    step();
    rate_wr = 1'b0;
  endtask

  task automatic clear_pulse(input logic b);
    flag_w1c_wr = 1'b1; flag_w1c_bit = b;
    step();
    flag_w1c_wr = 1'b0; flag_w1c_bit = 1'b0;
  endtask

  task automatic write_en(input logic v);
    en_wr = 1'b1; en_wdata = v;
    step();
    en_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) step();
    // R1: reset state
    chk("R1 flag", int'(flag_q), 0);
    chk("R1 en", int'(en_q), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 rate", int'(rate_q), 0);
    rst = 1'b0;
    wait_flag(n);
    chk("R2 first period after reset", n, period(0));

    for (int r = 0; r < 4; r++) begin
      int p;
      p = period(r);
      clear_pulse(1'b1);
      write_rate(r);
      chk("R9 rate readback", int'(rate_q), r);
      chk("R4 flag after rate write", int'(flag_q), 0);
      wait_flag(n);
      chk("R2 period for rate", n, p);

      // R3 / R5: clear at every offset inside the period, next expiry fixed
      for (int d = 1; d < p; d++) begin
        for (int i = 1; i <= p; i++) begin
          if (i == d) begin flag_w1c_wr = 1'b1; flag_w1c_bit = 1'b1; end
          step();
          flag_w1c_wr = 1'b0; flag_w1c_bit = 1'b0;
          if (i == d) chk("R5 clear with one", int'(flag_q), 0);
          if (i == p - 1) chk("R3 no early expiry", int'(flag_q), 0);
          if (i == p) chk("R3 drift-free expiry", int'(flag_q), 1);
        end
      end

      // R4: restart at early, middle and terminal offsets
      for (int k = 0; k < 3; k++) begin
        int o;
        o = (k == 0) ? 1 : (k == 1) ? p / 2 : p;
        for (int i = 1; i <= o; i++) begin
          if (i == 1) begin flag_w1c_wr = 1'b1; flag_w1c_bit = 1'b1; end
          if (i == o) begin rate_wr = 1'b1; rate_wdata = RATE_W'(r); end
          step();
          flag_w1c_wr = 1'b0; flag_w1c_bit = 1'b0; rate_wr = 1'b0;
        end
        chk("R4 restart does not set flag", int'(flag_q), 0);
        wait_flag(n);
        chk("R4 period restarts from write", n, p);
      end

      // R6: clear colliding with expiry
      for (int i = 1; i <= p; i++) begin
        if (i == 1 || i == p) begin flag_w1c_wr = 1'b1; flag_w1c_bit = 1'b1; end
        step();
        flag_w1c_wr = 1'b0; flag_w1c_bit = 1'b0;
        if (i == 1) chk("R5 clear before collision", int'(flag_q), 0);
      end
      chk("R6 set wins over clear", int'(flag_q), 1);
    end

    // R5: zero on the clear port has no effect
    clear_pulse(1'b0);
    chk("R5 zero write keeps flag", int'(flag_q), 1);

    // R7 / R8: interrupt gating
    write_rate(0);
    clear_pulse(1'b1);
    wait_flag(n);
    chk("R7 irq low while disabled", int'(irq), 0);
    write_en(1'b1);
    chk("R8 enable loaded", int'(en_q), 1);
    chk("R7 irq with flag and enable", int'(irq), 1);
    clear_pulse(1'b1);
    chk("R7 irq drops on clear", int'(irq), 0);
    chk("R8 enable retained", int'(en_q), 1);
    wait_flag(n);
    chk("R7 irq rises with flag", int'(irq), 1);
    write_en(1'b0);
    chk("R7 irq drops on disable", int'(irq), 0);

    // R1: reset in mid-run
    write_rate(3);
    write_en(1'b1);
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R1 flag after reset", int'(flag_q), 0);
    chk("R1 en after reset", int'(en_q), 0);
    chk("R1 irq after reset", int'(irq), 0);
    chk("R1 rate after reset", int'(rate_q), 0);
    wait_flag(n);
    chk("R2 base period after mid-run reset", n, period(0));

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule